// File: doc/BRIEF.md
# Line-Oriented Hex Record Decoder

This block turns a stream of ASCII characters carrying hexadecimal programming records into addressed data bytes. Each line starts with an `S` marker and a decimal type digit. A byte count, a big-endian address, a run of data bytes and a check byte follow, all written as pairs of uppercase hex characters. The block takes one character per accepted handshake cycle. It assembles the fields and forwards every payload byte together with its target byte address on a valid/ready port, so a downstream writer can place it in non-volatile storage.

At the end of every line the decoder raises a one-cycle report. The report carries the record type, the address read from the line, a good/bad verdict and exactly one error cause when the line is bad. Payload bytes leave as soon as they are decoded, before the line's check byte has been seen. The consumer holds them until the report arrives and drops them if the verdict is bad.

The control is a seven-state machine:
- `ST_WAIT_S`: idle between lines.
- `ST_TYPE`: the type digit.
- `ST_CNT_HI` and `ST_CNT_LO`: the two count nibbles.
- `ST_BYTE_HI` and `ST_BYTE_LO`: the two nibbles of each body byte.
- `ST_DISCARD`: skips the rest of a line already known to be bad.

Every state returns to `ST_WAIT_S` on an end-of-line character. A legal character moves each field state to the next one. An illegal character moves a field state to `ST_DISCARD`. `ST_BYTE_LO` loops back to `ST_BYTE_HI` after each byte.

Top module: `srec_line_decoder`

## Requirements
- R1: A line whose first character is not `S` (0x53) raises err_start in its report, emits no data byte, and the rest of the line up to the line end is ignored.
- R2: The character after `S` must be a decimal digit `0`..`9` and is reported on rec_type. It selects the address length: types 2 and 8 use 3 address bytes, types 3 and 7 use 4, and all other types use 2.
- R3: The count byte must equal the number of body bytes (address, data and check) that follow it and must be at least the address length plus one. A mismatch, or a line that ends before its body, raises err_len.
- R4: The 8-bit sum of the count byte and every body byte, check byte included, must be 0xFF. Otherwise err_sum is raised, provided no other error applies.
- R5: Only `0`..`9` and `A`..`F` are hex digits. Any other character in a hex field, lowercase letters included, and any non-digit type character raise err_char and the rest of the line is ignored.
- R6: For types 1, 2 and 3 only, each data byte leaves on out_data with out_addr equal to the record address plus the byte's index within the data field. Bytes leave as they are decoded, whatever the later verdict. Bytes past the count are never emitted.
- R7: rec_addr reports the address assembled from the line, which for types 7, 8 and 9 is the start address.
- R8: Either CR (0x0D) or LF (0x0A) ends a line. A line end seen while idle, such as the LF of a CR LF pair or a blank line, produces no report.
- R9: While out_valid is high and out_ready low, out_addr and out_data hold and in_ready is low, so no character or byte is lost or duplicated.
- R10: rec_done is high for exactly one cycle per ended line. A bad report has exactly one of err_start, err_char, err_len and err_sum set. rec_ok is high exactly when none is set.
- R11: After reset, out_valid and rec_done are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A character is offered |
| in_char | input | 8 | ASCII character |
| in_ready | output | 1 | Character taken on this edge when in_valid is high |
| out_valid | output | 1 | A decoded data byte is present |
| out_ready | input | 1 | Consumer takes the byte |
| out_addr | output | 32 | Target byte address of out_data |
| out_data | output | 8 | Decoded data byte |
| rec_done | output | 1 | One-cycle line report strobe |
| rec_type | output | 4 | Record type digit of the line |
| rec_ok | output | 1 | Line passed every check |
| rec_addr | output | 32 | Address assembled from the line |
| err_start | output | 1 | First character was not `S` |
| err_char | output | 1 | Illegal character in a digit field |
| err_len | output | 1 | Count does not match the body |
| err_sum | output | 1 | Checksum did not reach 0xFF |

## Verification
The assertions check on every cycle that a stalled byte keeps its address and data, and that out_valid falls only after a taken transfer. They also check that each report is a single-cycle pulse whose verdict and error flags agree, with exactly one cause per bad line. Only the bench's scenarios can show the rest, because it depends on the characters that make up a line. That covers the address length chosen per type digit, the byte addresses counted from the record address, the exact error raised by each kind of corruption, and the silent handling of CR LF pairs and blank lines. The bench sweeps all ten type digits, several payload lengths, every corruption kind and three consumer stall patterns.

// File: rtl/srec_pkg.sv
package srec_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_S,
        ST_TYPE,
        ST_CNT_HI,
        ST_CNT_LO,
        ST_BYTE_HI,
        ST_BYTE_LO,
        ST_DISCARD
    } srec_state_e;

    typedef struct packed {
        logic bad_start;
        logic bad_char;
        logic bad_len;
        logic bad_sum;
    } srec_err_t;

    localparam logic [7:0] CH_S  = 8'h53;
    localparam logic [7:0] CH_CR = 8'h0D;
    localparam logic [7:0] CH_LF = 8'h0A;

endpackage

// File: rtl/srec_char_class.sv
module srec_char_class
    import srec_pkg::*;
(
    input  logic [7:0] ch,
    output logic       is_dec,
    output logic       is_hex,
    output logic [3:0] nib,
    output logic       is_eol,
    output logic       is_start
);
    logic is_upper_af;

    always_comb begin
        is_dec      = (ch >= 8'h30) && (ch <= 8'h39);
        is_upper_af = (ch >= 8'h41) && (ch <= 8'h46);
        is_hex      = is_dec || is_upper_af;
        nib         = is_dec ? ch[3:0] : (ch[3:0] + 4'd9);
        is_eol      = (ch == CH_CR) || (ch == CH_LF);
        is_start    = (ch == CH_S);
    end
endmodule

// File: rtl/srec_type_map.sv
module srec_type_map #(
    parameter int MAX_ADDR_BYTES = 4,
    localparam int CW = $clog2(MAX_ADDR_BYTES + 1)
) (
    input  logic [3:0]    rtype,
    output logic [CW-1:0] addr_bytes,
    output logic          carries_data
);
    always_comb begin
        unique case (rtype)
            4'd2, 4'd8: addr_bytes = CW'(3);
            4'd3, 4'd7: addr_bytes = CW'(4);
            default:    addr_bytes = CW'(2);
        endcase
        carries_data = (rtype == 4'd1) || (rtype == 4'd2) || (rtype == 4'd3);
    end
endmodule

// File: rtl/srec_out_slot.sv
module srec_out_slot #(
    parameter int AW = 32,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_data,
    output logic          free
);
    assign free = !out_valid || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_addr  <= ld_addr;
            out_data  <= ld_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/srec_line_decoder.sv
module srec_line_decoder
    import srec_pkg::*;
#(
    parameter int MAX_ADDR_BYTES = 4,
    localparam int AW = 8 * MAX_ADDR_BYTES,
    localparam int CW = $clog2(MAX_ADDR_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_char,
    output logic          in_ready,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [AW-1:0] out_addr,
    output logic [7:0]    out_data,
    output logic          rec_done,
    output logic [3:0]    rec_type,
    output logic          rec_ok,
    output logic [AW-1:0] rec_addr,
    output logic          err_start,
    output logic          err_char,
    output logic          err_len,
    output logic          err_sum
);
    srec_state_e   state, nxt;
    logic          is_dec, is_hex, is_eol, is_start;
    logic [3:0]    nib;
    logic [CW-1:0] ab;
    logic [7:0]    ab_ext;
    logic          carries;
    logic [3:0]    rtype, hi_nib;
    logic [7:0]    cnt, sum, rcv;
    logic          over;
    logic [AW-1:0] base;
    srec_err_t     drain_err, verdict;
    logic          acc, line_end, emit, slot_free, hex_field;
    logic [7:0]    byte_val;
    logic [AW-1:0] emit_addr;

    srec_char_class u_class (
        .ch(in_char), .is_dec(is_dec), .is_hex(is_hex), .nib(nib),
        .is_eol(is_eol), .is_start(is_start)
    );

    srec_type_map #(.MAX_ADDR_BYTES(MAX_ADDR_BYTES)) u_map (
        .rtype(rtype), .addr_bytes(ab), .carries_data(carries)
    );

    assign in_ready  = slot_free;
    assign acc       = in_valid && in_ready;
    assign byte_val  = {hi_nib, nib};
    assign ab_ext    = {{(8-CW){1'b0}}, ab};
    assign hex_field = (state == ST_CNT_HI) || (state == ST_CNT_LO) ||
                       (state == ST_BYTE_HI) || (state == ST_BYTE_LO);
    assign line_end  = acc && is_eol && (state != ST_WAIT_S);
    assign emit      = acc && (state == ST_BYTE_LO) && is_hex && carries &&
                       (rcv >= ab_ext) && (({1'b0, rcv} + 9'd1) < {1'b0, cnt});
    assign emit_addr = base + AW'(rcv - ab_ext);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_WAIT_S:  if (acc && !is_eol) nxt = is_start ? ST_TYPE : ST_DISCARD;
            ST_TYPE:    if (acc) nxt = is_eol ? ST_WAIT_S : (is_dec ? ST_CNT_HI : ST_DISCARD);
            ST_CNT_HI:  if (acc) nxt = is_eol ? ST_WAIT_S : (is_hex ? ST_CNT_LO : ST_DISCARD);
            ST_CNT_LO:  if (acc) nxt = is_eol ? ST_WAIT_S : (is_hex ? ST_BYTE_HI : ST_DISCARD);
            ST_BYTE_HI: if (acc) nxt = is_eol ? ST_WAIT_S : (is_hex ? ST_BYTE_LO : ST_DISCARD);
            ST_BYTE_LO: if (acc) nxt = is_eol ? ST_WAIT_S : (is_hex ? ST_BYTE_HI : ST_DISCARD);
            ST_DISCARD: if (acc && is_eol) nxt = ST_WAIT_S;
            default:    nxt = ST_WAIT_S;
        endcase
    end

    // line verdict at the line end
    always_comb begin
        verdict = '0;
        if (state == ST_DISCARD) begin
            verdict = drain_err;
        end else if ((state != ST_BYTE_HI) || over || (rcv != cnt) || (cnt <= ab_ext)) begin
            verdict.bad_len = 1'b1;
        end else if (sum != 8'hFF) begin
            verdict.bad_sum = 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WAIT_S;
        else        state <= nxt;
    end

    // field datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rtype     <= '0;
            hi_nib    <= '0;
            cnt       <= '0;
            sum       <= '0;
            rcv       <= '0;
            over      <= 1'b0;
            base      <= '0;
            drain_err <= '0;
        end else if (acc) begin
            if (hex_field && !is_eol && !is_hex) drain_err <= srec_err_t'(4'b0100);
            unique case (state)
                ST_WAIT_S: begin
                    if (!is_eol) begin
                        if (is_start) begin
                            base      <= '0;
                            drain_err <= '0;
                        end else begin
                            drain_err <= srec_err_t'(4'b1000);
                        end
                    end
                end
                ST_TYPE: begin
                    if (is_dec) rtype <= in_char[3:0];
                    else if (!is_eol) drain_err <= srec_err_t'(4'b0100);
                end
                ST_CNT_HI, ST_BYTE_HI: hi_nib <= nib;
                ST_CNT_LO: begin
                    if (is_hex) begin
                        cnt  <= byte_val;
                        sum  <= byte_val;
                        rcv  <= '0;
                        over <= 1'b0;
                    end
                end
                ST_BYTE_LO: begin
                    if (is_hex) begin
                        sum <= sum + byte_val;
                        if (rcv == cnt) over <= 1'b1;
                        else            rcv  <= rcv + 8'd1;
                        if (rcv < ab_ext) base <= {base[AW-9:0], byte_val};
                    end
                end
                default: ;
            endcase
        end
    end

    // line report outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_done  <= 1'b0;
            rec_type  <= '0;
            rec_ok    <= 1'b0;
            rec_addr  <= '0;
            err_start <= 1'b0;
            err_char  <= 1'b0;
            err_len   <= 1'b0;
            err_sum   <= 1'b0;
        end else begin
            rec_done <= line_end;
            if (line_end) begin
                rec_type  <= rtype;
                rec_addr  <= base;
                rec_ok    <= (verdict == '0);
                err_start <= verdict.bad_start;
                err_char  <= verdict.bad_char;
                err_len   <= verdict.bad_len;
                err_sum   <= verdict.bad_sum;
            end
        end
    end

    srec_out_slot #(.AW(AW), .DW(8)) u_slot (
        .clk(clk), .rst_n(rst_n), .load(emit), .ld_addr(emit_addr), .ld_data(byte_val),
        .out_ready(out_ready), .out_valid(out_valid), .out_addr(out_addr),
        .out_data(out_data), .free(slot_free)
    );
endmodule

// File: rtl/srec_line_decoder_chk.sv
module srec_line_decoder_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          out_valid,
    input logic          out_ready,
    input logic [AW-1:0] out_addr,
    input logic [7:0]    out_data,
    input logic          rec_done,
    input logic          rec_ok,
    input logic          err_start,
    input logic          err_char,
    input logic          err_len,
    input logic          err_sum
);
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_data))); // R9

    AST_DROP_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> $past(out_ready)); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done |=> !rec_done); // R10

    AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done |-> (rec_ok ? ({err_start, err_char, err_len, err_sum} == 4'b0000)
                             : ($countones({err_start, err_char, err_len, err_sum}) == 1))); // R10
endmodule

bind srec_line_decoder srec_line_decoder_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_data(out_data), .rec_done(rec_done), .rec_ok(rec_ok),
    .err_start(err_start), .err_char(err_char), .err_len(err_len), .err_sum(err_sum)
);

// File: tb/srec_line_decoder_test.sv
`timescale 1ns/100ps
module srec_line_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_char = 8'h00;
    logic        in_ready;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_addr;
    logic [7:0]  out_data;
    logic        rec_done;
    logic [3:0]  rec_type;
    logic        rec_ok;
    logic [31:0] rec_addr;
    logic        err_start, err_char, err_len, err_sum;

    int n_chk = 0;
    int n_fail = 0;
    int rp = 0;
    logic [15:0] lfsr = 16'hACE1;

    logic [39:0] exp_b[$];
    logic [40:0] exp_r[$];
    string       exp_tag[$];

    srec_line_decoder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_char(in_char), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_data(out_data),
        .rec_done(rec_done), .rec_type(rec_type), .rec_ok(rec_ok), .rec_addr(rec_addr),
        .err_start(err_start), .err_char(err_char), .err_len(err_len), .err_sum(err_sum)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rp)
            0:       out_ready <= 1'b1;
            1:       out_ready <= lfsr[0];
            default: out_ready <= (lfsr[2:0] == 3'd0);
        endcase
    end

    // monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && !out_ready) begin
                n_chk++;
                if (in_ready !== 1'b0) begin
                    n_fail++;
                    $display("FAIL R9 in_ready during stall: got %b expected 0", in_ready);
                end
            end
            if (out_valid && out_ready) begin
                n_chk++;
                if (exp_b.size() == 0) begin
                    n_fail++;
                    $display("FAIL R6 unexpected byte: got addr %h data %h expected none", out_addr, out_data);
                end else begin
                    logic [39:0] e;
                    e = exp_b.pop_front();
                    if ({out_addr, out_data} !== e) begin
                        n_fail++;
                        $display("FAIL R6 byte: got addr %h data %h expected addr %h data %h",
                                 out_addr, out_data, e[39:8], e[7:0]);
                    end
                end
            end
            if (rec_done) begin
                n_chk++;
                if (exp_r.size() == 0) begin
                    n_fail++;
                    $display("FAIL R8 unexpected report: got flags %b expected none",
                             {rec_ok, err_start, err_char, err_len, err_sum});
                end else begin
                    logic [40:0] r;
                    string t;
                    r = exp_r.pop_front();
                    t = exp_tag.pop_front();
                    if ({rec_ok, err_start, err_char, err_len, err_sum} !== r[40:36]) begin
                        n_fail++;
                        $display("FAIL %s/R10 verdict: got %b expected %b", t,
                                 {rec_ok, err_start, err_char, err_len, err_sum}, r[40:36]);
                    end else if (r[40] && ({rec_type, rec_addr} !== r[35:0])) begin
                        n_fail++;
                        $display("FAIL %s/R7 type/addr: got %h/%h expected %h/%h", t,
                                 rec_type, rec_addr, r[35:32], r[31:0]);
                    end
                end
            end
        end
    end

    function automatic logic [7:0] hexc(input logic [3:0] n);
        return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h41 + {4'h0, n} - 8'd10);
    endfunction

    task automatic put_char(input logic [7:0] c);
        @(negedge clk);
        in_valid = 1'b1;
        in_char  = c;
        #0.1;
        while (!in_ready) begin
            @(negedge clk);
            #0.1;
        end
        @(posedge clk);
    endtask

    // mode: 0 good, 1 bad sum, 2 count+1, 3 count-1, 4 lowercase, 5 bad start, 6 bad type, 7 truncated
    task automatic run_rec(input int t, input logic [31:0] a, input int nd, input int mode, input int eolk);
        logic [7:0]  body[$];
        logic [7:0]  s, chk, cntf;
        logic [31:0] am;
        int ab, realn, cnt;
        logic [4:0] fl;
        string tag;
        ab = (t == 2 || t == 8) ? 3 : ((t == 3 || t == 7) ? 4 : 2);
        am = (ab == 4) ? a : (a & ((32'h1 << (8 * ab)) - 32'h1));
        for (int i = ab - 1; i >= 0; i--) body.push_back(am[8*i +: 8]);
        for (int i = 0; i < nd; i++) body.push_back(8'((t * 37 + i * 11 + nd * 5 + 3)));
        realn = ab + nd + 1;
        cnt = (mode == 2) ? realn + 1 : ((mode == 3) ? realn - 1 : realn);
        cntf = 8'(cnt);
        s = cntf;
        foreach (body[i]) s = s + body[i];
        chk = 8'hFF - s;
        if (mode == 1) chk = chk ^ 8'h01;
        body.push_back(chk);
        // expected bytes
        if (mode <= 3 && t >= 1 && t <= 3) begin
            for (int k = ab; k < body.size(); k++)
                if (k + 1 < cnt) exp_b.push_back({am + 32'(k - ab), body[k]});
        end
        case (mode)
            0: begin fl = 5'b10000; tag = "R2/R4"; end
            1: begin fl = 5'b00001; tag = "R4"; end
            2, 3, 7: begin fl = 5'b00010; tag = "R3"; end
            4, 6: begin fl = 5'b00100; tag = "R5"; end
            default: begin fl = 5'b01000; tag = "R1"; end
        endcase
        exp_r.push_back({fl, 4'(t), am});
        exp_tag.push_back(tag);
        // drive characters
        put_char(mode == 5 ? 8'h51 : 8'h53);
        put_char(mode == 6 ? 8'h41 : (8'h30 + 8'(t)));
        put_char(hexc(cntf[7:4]));
        put_char(hexc(cntf[3:0]));
        if (mode != 7) begin
            foreach (body[k]) begin
                put_char((mode == 4 && k == 0) ? 8'h63 : hexc(body[k][7:4]));
                put_char(hexc(body[k][3:0]));
            end
        end
        case (eolk)
            0: put_char(8'h0D);
            1: put_char(8'h0A);
            2: begin put_char(8'h0D); put_char(8'h0A); end
            default: begin put_char(8'h0A); put_char(8'h0A); end
        endcase
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        n_chk++;
        if (out_valid !== 1'b0 || rec_done !== 1'b0 || in_ready !== 1'b1) begin
            n_fail++;
            $display("FAIL R11 reset: got valid %b done %b ready %b expected 0 0 1",
                     out_valid, rec_done, in_ready);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R8 blank line while idle gives no report
        put_char(8'h0A);
        put_char(8'h0D);
        for (int p = 0; p < 3; p++) begin
            rp = p;
            for (int t = 0; t < 10; t++)
                for (int nd = 0; nd < 5; nd++)
                    run_rec(t, 32'hFFFF_FFFE - 32'(t * 4099 + nd * 77), nd, 0, (t + nd) % 4);
            for (int m = 1; m < 8; m++)
                for (int t = 0; t < 10; t++)
                    run_rec(t, 32'h1234_5678 + 32'(m * 513 + t), 1 + (t % 3), m, (m + t) % 4);
        end
        @(negedge clk);
        in_valid = 1'b0;
        rp = 0;
        repeat (20) @(negedge clk);
        n_chk++;
        if (exp_b.size() != 0 || exp_r.size() != 0) begin
            n_fail++;
            $display("FAIL R6/R10 leftovers: got %0d bytes %0d reports pending expected 0 0",
                     exp_b.size(), exp_r.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule